// File: doc/BRIEF.md
# Serial Port FIFO, Status and Interrupt Unit

This block sits between a host register interface and a serial shifter. It holds words waiting to be sent in a transmit queue and words that have arrived in a receive queue. Both queues are eight entries deep and sixteen bits wide by default. The host pushes transmit words with a write strobe. It pops received words with a read strobe and sees the oldest received word on a show-ahead data output. The shifter takes the oldest transmit word with a take strobe and delivers arrivals with a put strobe. A bit-period tick from the serial side times the receive idle period.

From the queue fill levels, the block derives a five-bit status word and four interrupt conditions. Two conditions are levels computed from the fill thresholds. The other two are sticky events that software clears: receive overrun and receive timeout. The raw conditions are ANDed with a host mask to give the masked conditions, and the masked bits are ORed into one interrupt line. Two request lines, each gated by its own enable, let a DMA engine service the queues.

Top module: `sport_fifo_ctrl`

## Requirements
- R1: After reset both queues are empty, `status_o` is 5'b00011 when `shift_active_i` is low, `raw_irq_o` is 4'b1000, and both DMA requests are low while `dma_en_i` is zero.
- R2: The bits of `status_o` are: [0] transmit queue empty, [1] transmit queue not full, [2] receive queue not empty, [3] receive queue full, [4] busy. Busy is high when the transmit queue holds a word or `shift_active_i` is high. All bits follow the queue counts as they stand after the last clock edge.
- R3: Words pass through each queue in the order they entered. `tx_word_o` and `host_rdata_o` show the oldest entry. A host write to a full transmit queue is dropped unless a take happens in the same cycle. A read or take of an empty queue is ignored.
- R4: Bit [2] of `raw_irq_o` is high while the receive queue holds 4 or more words. Bit [3] is high while the transmit queue holds 4 or fewer words. Both bits are levels with no clear.
- R5: `rx_put_i` with the receive queue full and no host read in the same cycle drops the word. It also sets `raw_irq_o[0]` from the next cycle on, and the bit stays set until it is cleared.
- R6: `raw_irq_o[1]` sets when the receive queue is non-empty and 32 `bit_tick_i` pulses pass with no accepted receive word and no host read. Either event restarts the count. The bit clears on a host read that takes a word.
- R7: In `irq_clr_i`, bit [0] clears overrun and bit [1] clears timeout. A zero bit has no effect. If a flag is set and cleared in the same cycle, the set wins.
- R8: `masked_irq_o` is `raw_irq_o` AND `irq_mask_i`, and `irq_o` is the OR of `masked_irq_o`. The raw bits ignore the mask.
- R9: `dma_rx_req_o` is high while the receive queue is non-empty and `dma_en_i[0]` is set. `dma_tx_req_o` is high while the transmit queue is not full and `dma_en_i[1]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Push `host_wdata_i` into the transmit queue |
| host_wdata_i | input | DW | Transmit word from the host |
| host_rd_i | input | 1 | Pop the oldest received word |
| host_rdata_o | output | DW | Oldest received word (show-ahead) |
| irq_mask_i | input | 4 | Interrupt enable per condition |
| irq_clr_i | input | 2 | Clear strobes: [0] overrun, [1] timeout |
| dma_en_i | input | 2 | DMA enables: [0] receive, [1] transmit |
| bit_tick_i | input | 1 | One pulse per serial bit period |
| shift_active_i | input | 1 | Shifter is in the middle of a frame |
| tx_take_i | input | 1 | Shifter consumes the oldest transmit word |
| tx_word_o | output | DW | Oldest transmit word |
| rx_put_i | input | 1 | Shifter delivers a received word |
| rx_word_i | input | DW | Received word |
| status_o | output | 5 | Queue and busy status |
| raw_irq_o | output | 4 | Conditions: [0] overrun, [1] timeout, [2] receive half full, [3] transmit half empty |
| masked_irq_o | output | 4 | Raw conditions ANDed with the mask |
| irq_o | output | 1 | OR of the masked conditions |
| dma_rx_req_o | output | 1 | Receive service request |
| dma_tx_req_o | output | 1 | Transmit service request |

## Verification
A strobe at a clock edge changes the queue counts and the sticky flags at that edge. Every count-derived output is therefore due in the cycle that follows, with no further register on the way. The mask, the enables and `shift_active_i` reach their outputs through logic only, in the same cycle. The bench applies inputs just after each falling edge and advances a queue-based model at the rising edge. It compares every output at the next falling edge against the model state combined with the inputs still applied, which lines each check up with the single register stage.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int ST_TX_EMPTY  = 0;
  localparam int ST_TX_NFULL  = 1;
  localparam int ST_RX_NEMPTY = 2;
  localparam int ST_RX_FULL   = 3;
  localparam int ST_BUSY      = 4;
  localparam int ST_W         = 5;

  localparam int IRQ_OVR      = 0;
  localparam int IRQ_TMO      = 1;
  localparam int IRQ_RX_HALF  = 2;
  localparam int IRQ_TX_HALF  = 3;
  localparam int IRQ_W        = 4;

  localparam int DMA_RX       = 0;
  localparam int DMA_TX       = 1;
endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign pop_ok_o  = pop_i & ~empty_o;
  // a full queue still accepts a word if one leaves in the same cycle
  assign push_ok_o = push_i & (~full_o | pop_ok_o);
  assign head_o    = mem_q[rd_ptr_q];
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_ok_o)  rd_ptr_q <= rd_ptr_q + AW'(1);
      if (push_ok_o && !pop_ok_o)      cnt_q <= cnt_q + CW'(1);
      else if (pop_ok_o && !push_ok_o) cnt_q <= cnt_q - CW'(1);
    end
  end

  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r3_empty_pop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
  a_r3_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o && $stable(wr_ptr_q));
endmodule

// File: rtl/sport_rx_timeout.sv
module sport_rx_timeout #(
  parameter int TMO_BITS = 32,
  localparam int TW      = $clog2(TMO_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic nonempty_i,
  input  logic tick_i,
  output logic hit_o
);
  logic [TW-1:0] cnt_q;

  // counter saturates at TMO_BITS so the event fires once per idle spell
  assign hit_o = ~restart_i & nonempty_i & tick_i & (cnt_q == TW'(TMO_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || !nonempty_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != TW'(TMO_BITS)) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(TMO_BITS));
  a_r6_restart_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/sport_irq_unit.sv
module sport_irq_unit
  import sport_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovr_set_i,
  input  logic             tmo_set_i,
  input  logic             rx_pop_i,
  input  logic [1:0]       clr_i,
  input  logic             rx_half_i,
  input  logic             tx_half_i,
  input  logic [IRQ_W-1:0] mask_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] masked_o,
  output logic             irq_o
);
  logic ovr_q, tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      if (ovr_set_i)     ovr_q <= 1'b1;
      else if (clr_i[0]) ovr_q <= 1'b0;
      if (tmo_set_i)                    tmo_q <= 1'b1;
      else if (clr_i[1] || rx_pop_i)    tmo_q <= 1'b0;
    end
  end

  always_comb begin
    raw_o              = '0;
    raw_o[IRQ_OVR]     = ovr_q;
    raw_o[IRQ_TMO]     = tmo_q;
    raw_o[IRQ_RX_HALF] = rx_half_i;
    raw_o[IRQ_TX_HALF] = tx_half_i;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  a_r5_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o[IRQ_OVR] && !clr_i[0]) |=> raw_o[IRQ_OVR]);
  a_r5_ovr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_o[IRQ_OVR]) |-> $past(ovr_set_i));
  a_r7_ovr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && !ovr_set_i) |=> !raw_o[IRQ_OVR]);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_set_i && clr_i[0]) |=> raw_o[IRQ_OVR]);
  a_r6_tmo_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i[1] || rx_pop_i) && !tmo_set_i) |=> !raw_o[IRQ_TMO]);
  a_r6_tmo_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_o[IRQ_TMO]) |-> $past(tmo_set_i));
endmodule

// File: rtl/sport_fifo_ctrl.sv
module sport_fifo_ctrl
  import sport_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DEPTH    = 8,
  parameter int TMO_BITS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_wr_i,
  input  logic [DW-1:0]    host_wdata_i,
  input  logic             host_rd_i,
  output logic [DW-1:0]    host_rdata_o,
  input  logic [IRQ_W-1:0] irq_mask_i,
  input  logic [1:0]       irq_clr_i,
  input  logic [1:0]       dma_en_i,
  input  logic             bit_tick_i,
  input  logic             shift_active_i,
  input  logic             tx_take_i,
  output logic [DW-1:0]    tx_word_o,
  input  logic             rx_put_i,
  input  logic [DW-1:0]    rx_word_i,
  output logic [ST_W-1:0]  status_o,
  output logic [IRQ_W-1:0] raw_irq_o,
  output logic [IRQ_W-1:0] masked_irq_o,
  output logic             irq_o,
  output logic             dma_rx_req_o,
  output logic             dma_tx_req_o
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, tx_push_ok, tx_pop_ok;
  logic rx_full, rx_empty, rx_push_ok, rx_pop_ok;
  logic ovr_set, tmo_hit;

  sport_fifo #(.DW(DW), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(host_wr_i), .data_i(host_wdata_i), .pop_i(tx_take_i),
    .head_o(tx_word_o), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty),
    .push_ok_o(tx_push_ok), .pop_ok_o(tx_pop_ok)
  );

  sport_fifo #(.DW(DW), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_put_i), .data_i(rx_word_i), .pop_i(host_rd_i),
    .head_o(host_rdata_o), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty),
    .push_ok_o(rx_push_ok), .pop_ok_o(rx_pop_ok)
  );

  assign ovr_set = rx_put_i & ~rx_push_ok;

  sport_rx_timeout #(.TMO_BITS(TMO_BITS)) i_rx_timeout (
    .clk_i, .rst_ni,
    .restart_i(rx_push_ok | rx_pop_ok), .nonempty_i(~rx_empty),
    .tick_i(bit_tick_i), .hit_o(tmo_hit)
  );

  sport_irq_unit i_irq_unit (
    .clk_i, .rst_ni,
    .ovr_set_i(ovr_set), .tmo_set_i(tmo_hit), .rx_pop_i(rx_pop_ok),
    .clr_i(irq_clr_i),
    .rx_half_i(rx_cnt >= CW'(HALF)), .tx_half_i(tx_cnt <= CW'(HALF)),
    .mask_i(irq_mask_i),
    .raw_o(raw_irq_o), .masked_o(masked_irq_o), .irq_o(irq_o)
  );

  always_comb begin
    status_o               = '0;
    status_o[ST_TX_EMPTY]  = tx_empty;
    status_o[ST_TX_NFULL]  = ~tx_full;
    status_o[ST_RX_NEMPTY] = ~rx_empty;
    status_o[ST_RX_FULL]   = rx_full;
    status_o[ST_BUSY]      = ~tx_empty | shift_active_i;
  end

  assign dma_rx_req_o = dma_en_i[DMA_RX] & ~rx_empty;
  assign dma_tx_req_o = dma_en_i[DMA_TX] & ~tx_full;

  a_r5_drop_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set |=> rx_cnt == CW'(DEPTH));
  a_r3_tx_drop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !tx_push_ok) |=> tx_cnt == CW'(DEPTH));
  a_r3_take_empty_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_take_i && !tx_pop_ok && !host_wr_i) |=> tx_empty);
  a_r9_dma_rx_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rx_req_o |-> rx_cnt != '0);
  a_r9_dma_tx_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_tx_req_o |-> tx_cnt != CW'(DEPTH));
  a_r6_tmo_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_hit |-> rx_cnt != '0);
endmodule

// File: tb/test_sport_fifo_ctrl.sv
`timescale 1ns/1ps
module test_sport_fifo_ctrl;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int TMO = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic host_wr = 0, host_rd = 0, bit_tick = 0, shift_active = 0, tx_take = 0, rx_put = 0;
  logic [DW-1:0] host_wdata = '0, rx_word = '0, host_rdata, tx_word;
  logic [3:0] irq_mask = '0, raw_irq, masked_irq;
  logic [1:0] irq_clr = '0, dma_en = '0;
  logic [4:0] status;
  logic irq, dma_rx_req, dma_tx_req;

  int n_chk = 0, n_bad = 0;
  int txq[$], rxq[$];
  bit m_ovr = 0, m_tmo = 0;
  int m_tcnt = 0;

  always #4 clk = ~clk;

  sport_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH), .TMO_BITS(TMO)) i_sport_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rd_i(host_rd), .host_rdata_o(host_rdata),
    .irq_mask_i(irq_mask), .irq_clr_i(irq_clr), .dma_en_i(dma_en),
    .bit_tick_i(bit_tick), .shift_active_i(shift_active),
    .tx_take_i(tx_take), .tx_word_o(tx_word),
    .rx_put_i(rx_put), .rx_word_i(rx_word),
    .status_o(status), .raw_irq_o(raw_irq), .masked_irq_o(masked_irq),
    .irq_o(irq), .dma_rx_req_o(dma_rx_req), .dma_tx_req_o(dma_tx_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic bit pick(input int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic compare_all();
    logic [4:0] st;
    logic [3:0] raw;
    st = {(txq.size() > 0) || shift_active, rxq.size() == DEPTH, rxq.size() > 0,
          txq.size() < DEPTH, txq.size() == 0};
    raw = {txq.size() <= DEPTH/2, rxq.size() >= DEPTH/2, m_tmo, m_ovr};
    chk("R2 status", 32'(status), 32'(st));
    chk("R4 level irq", 32'(raw_irq[3:2]), 32'(raw[3:2]));
    chk("R5 R7 overrun", 32'(raw_irq[0]), 32'(raw[0]));
    chk("R6 R7 timeout", 32'(raw_irq[1]), 32'(raw[1]));
    chk("R8 masked", 32'(masked_irq), 32'(raw & irq_mask));
    chk("R8 irq line", 32'(irq), 32'(|(raw & irq_mask)));
    chk("R9 dma rx", 32'(dma_rx_req), 32'(dma_en[0] && rxq.size() > 0));
    chk("R9 dma tx", 32'(dma_tx_req), 32'(dma_en[1] && txq.size() < DEPTH));
    if (txq.size() > 0) chk("R3 tx order", 32'(tx_word), 32'(txq[0]));
    if (rxq.size() > 0) chk("R3 rx order", 32'(host_rdata), 32'(rxq[0]));
  endtask

  task automatic model_step();
    bit rpop, rput, ovr_set, hit, tpop, tpush, restart;
    rpop = host_rd && rxq.size() > 0;
    rput = rx_put && (rxq.size() < DEPTH || rpop);
    ovr_set = rx_put && !rput;
    restart = rput || rpop;
    hit = !restart && rxq.size() > 0 && bit_tick && m_tcnt == TMO - 1;
    if (restart || rxq.size() == 0) m_tcnt = 0;
    else if (bit_tick && m_tcnt < TMO) m_tcnt++;
    if (ovr_set) m_ovr = 1; else if (irq_clr[0]) m_ovr = 0;
    if (hit) m_tmo = 1; else if (irq_clr[1] || rpop) m_tmo = 0;
    if (rpop) void'(rxq.pop_front());
    if (rput) rxq.push_back(int'(rx_word));
    tpop = tx_take && txq.size() > 0;
    tpush = host_wr && (txq.size() < DEPTH || tpop);
    if (tpop) void'(txq.pop_front());
    if (tpush) txq.push_back(int'(host_wdata));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL all: watchdog expired, actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ph;
    repeat (3) @(negedge clk);
    // R1: reset values with mask and DMA enables at zero
    chk("R1 status", 32'(status), 32'h03);
    chk("R1 raw", 32'(raw_irq), 32'h8);
    chk("R1 dma", 32'({dma_rx_req, dma_tx_req}), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      compare_all();
      ph = (cyc / 160) % 5;
      host_wdata = DW'($urandom);
      rx_word = DW'($urandom);
      shift_active = pick(20);
      if (pick(5)) irq_mask = 4'($urandom);
      if (pick(5)) dma_en = 2'($urandom);
      irq_clr = {pick(ph == 2 ? 2 : 8), pick(8)};
      case (ph)
        0: begin host_wr = pick(70); tx_take = pick(20); rx_put = pick(30); host_rd = pick(30); bit_tick = pick(30); end
        1: begin host_wr = pick(20); tx_take = pick(60); rx_put = pick(80); host_rd = pick(5);  bit_tick = pick(50); end
        2: begin host_wr = 0; tx_take = 0; rx_put = 0; host_rd = 0; bit_tick = 1; end
        3: begin host_wr = pick(50); tx_take = pick(50); rx_put = pick(50); host_rd = pick(50); bit_tick = pick(50); end
        default: begin host_wr = pick(20); tx_take = pick(70); rx_put = pick(20); host_rd = pick(70); bit_tick = pick(40); end
      endcase
      @(posedge clk);
      model_step();
    end
    @(negedge clk);
    compare_all();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule